// File: doc/BRIEF.md
# Dual-Bank Shared-Bus Memory Front End

This block models, on a system clock, a memory with two banks that share one address bus, one data bus and one set of strobes. The low bank is a static RAM. The high bank is a flash array that is only read through the bus. The array's contents are loaded through a separate preload port. Two active-low bank enables pick the bank. An active-low output enable and an active-low write enable control each access. With the default parameters the sizes are 32 x8 for the RAM and 64 x8 for the flash. At full size the same ratio gives 128K x8 and 256K x8.

Every strobe is sampled through a two-flop synchronizer. All decisions are made on the synchronized samples, so each bus output follows its inputs three clock edges later. A RAM write is open while the RAM enable and the write enable are both low and the flash enable is high. The write is committed when the first of those two strobes is seen rising. A window that is too short is rejected, and an error pulse reports it. The flash enable takes priority over the RAM enable, which keeps the two banks from ever driving the bus together. A standby output shows when neither bank is selected.

Top module: `combo_mem_bus`

## Requirements
- R1: After reset, `dout_en` is 0, `standby` is 1 and `wr_err` is 0.
- R2: `standby` is 1 exactly when both `flash_sel_n` and `sram_sel_n` were high three clock edges earlier.
- R3: `dout_en` is 1 only when, three edges earlier, `out_en_n` was low, `wr_en_n` was high and a bank was selected. While `out_en_n` is high, the bus is never driven.
- R4: When both bank enables are low, a read returns the flash word at `addr` and `sram_sel_n` is ignored.
- R5: The RAM occupies addresses 0 to 2^SRAM_AW-1. A RAM access with any address bit at position SRAM_AW or above drops the write, and a read of it drives 0.
- R6: A RAM write takes the address and data sampled on the clock where the first of `sram_sel_n` or `wr_en_n` is seen rising. Changes made after that edge and before the other strobe rises are not stored.
- R7: A RAM write window shorter than MIN_PULSE samples (default 3) stores nothing, and `wr_err` is high for exactly one cycle.
- R8: Write-enable activity while the flash enable is low changes neither bank. A RAM window that is cut short by the flash enable falling is dropped without an error pulse.
- R9: A preload (`pre_we` high) updates the flash only in a cycle where `standby` is 1. Otherwise it is ignored.
- R10: While `flash_busy` is high, flash reads leave the bus undriven, and RAM reads and writes work as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | FLASH_AW | Shared byte address |
| flash_sel_n | input | 1 | Flash bank enable, active low, dominant |
| sram_sel_n | input | 1 | RAM bank enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| wr_en_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data from the bus |
| flash_busy | input | 1 | Flash internal operation in progress |
| pre_we | input | 1 | Flash preload strobe |
| pre_addr | input | FLASH_AW | Flash preload address |
| pre_data | input | DATA_W | Flash preload data |
| dout | output | DATA_W | Read data toward the bus |
| dout_en | output | 1 | Bus drive enable (low means high impedance) |
| standby | output | 1 | Neither bank selected |
| wr_err | output | 1 | One-cycle pulse on a rejected short write |

## Verification
Checked on every cycle: the bus is never driven when output enable was high, the standby output matches the delayed enables, and a flash read wins when both enables are low unless the flash is busy. Also checked every cycle: a commit never coincides with an error, and neither pulse lasts more than one cycle. Only the bench can show the stored contents. That covers the latch point on the first rising strobe, the rejection of short windows, the dropping of writes above the RAM region or under the flash enable, and the refusal of preloads outside standby. The bench shows these by sweeping every address and every strobe combination and reading the banks back.

// File: rtl/combo_pkg.sv
package combo_pkg;

  // Order matches the packing {flash_sel_n, sram_sel_n, out_en_n, wr_en_n}
  typedef struct packed {
    logic flash_n;
    logic sram_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  localparam int STROBE_W = $bits(strobe_t);

endpackage

// File: rtl/sample_pipe.sv
module sample_pipe #(
  parameter int           W       = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st1_q, st2_q;
  logic [W-1:0] st1_d, st2_d;

  always_comb begin
    st1_d = d;
    st2_d = st1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1_q <= RST_VAL;
      st2_q <= RST_VAL;
    end else begin
      st1_q <= st1_d;
      st2_q <= st2_d;
    end
  end

  assign q = st2_q;

endmodule

// File: rtl/wr_window.sv
module wr_window #(
  parameter int AW        = 6,
  parameter int DW        = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_now,
  input  logic          abort_now,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] data_s,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data,
  output logic          wr_err
);

  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_PULSE);

  logic          win_q;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          end_now, long_enough;
  logic          commit_q, commit_d;
  logic          err_q, err_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_comb begin
    cnt_d = cnt_q;
    if (win_now) begin
      if (cnt_q != CNT_MAX) cnt_d = CW'(cnt_q + 1'b1);
    end else begin
      cnt_d = '0;
    end
    end_now     = win_q && !win_now;
    long_enough = (cnt_q >= CNT_MAX);
    commit_d    = end_now && !abort_now && long_enough;
    err_d       = end_now && !abort_now && !long_enough;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= 1'b0;
      cnt_q    <= '0;
      commit_q <= 1'b0;
      err_q    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      win_q    <= win_now;
      cnt_q    <= cnt_d;
      commit_q <= commit_d;
      err_q    <= err_d;
      if (commit_d) begin
        addr_q <= addr_s;
        data_q <= data_s;
      end
    end
  end

  assign commit      = commit_q;
  assign commit_addr = addr_q;
  assign commit_data = data_q;
  assign wr_err      = err_q;

  // R7: a window ends either in a commit or in an error, never both
  assert_commit_err_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit, wr_err}));
  assert_err_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> !wr_err);
  assert_commit_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
  assert_commit_after_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !$past(win_now));

endmodule

// File: rtl/sram_bank.sv
module sram_bank #(
  parameter int SRAM_AW = 5,
  parameter int ADDR_W  = 6,
  parameter int DW      = 8
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data
);

  localparam int DEPTH = 1 << SRAM_AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic          wr_hit, rd_hit;

  generate
    if (ADDR_W > SRAM_AW) begin : g_upper
      assign wr_hit = (wr_addr[ADDR_W-1:SRAM_AW] == '0);
      assign rd_hit = (rd_addr[ADDR_W-1:SRAM_AW] == '0);
    end else begin : g_flat
      assign wr_hit = 1'b1;
      assign rd_hit = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr && wr_hit) mem_q[wr_addr[SRAM_AW-1:0]] <= wr_data;
  end

  always_comb begin
    rd_data = rd_hit ? mem_q[rd_addr[SRAM_AW-1:0]] : '0;
  end

endmodule

// File: rtl/flash_bank.sv
module flash_bank #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          pre_wr,
  input  logic [AW-1:0] pre_addr,
  input  logic [DW-1:0] pre_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (pre_wr) arr_q[pre_addr] <= pre_data;
  end

  always_comb begin
    rd_data = arr_q[rd_addr];
  end

endmodule

// File: rtl/combo_mem_bus.sv
module combo_mem_bus
  import combo_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int FLASH_AW  = 6,
  parameter int SRAM_AW   = 5,
  parameter int MIN_PULSE = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [FLASH_AW-1:0] addr,
  input  logic                flash_sel_n,
  input  logic                sram_sel_n,
  input  logic                out_en_n,
  input  logic                wr_en_n,
  input  logic [DATA_W-1:0]   din,
  input  logic                flash_busy,
  input  logic                pre_we,
  input  logic [FLASH_AW-1:0] pre_addr,
  input  logic [DATA_W-1:0]   pre_data,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_en,
  output logic                standby,
  output logic                wr_err
);

  localparam int BUS_W = FLASH_AW + DATA_W;

  // Reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // Synchronized strobes (inactive high) and matching address/data samples
  logic [STROBE_W-1:0] strb_q;
  strobe_t             s_cur;
  logic [BUS_W-1:0]    bus_q;
  logic [FLASH_AW-1:0] addr_s;
  logic [DATA_W-1:0]   data_s;

  sample_pipe #(.W(STROBE_W), .RST_VAL({STROBE_W{1'b1}})) u_strobe_pipe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({flash_sel_n, sram_sel_n, out_en_n, wr_en_n}),
    .q     (strb_q)
  );

  sample_pipe #(.W(BUS_W), .RST_VAL({BUS_W{1'b0}})) u_bus_pipe (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d     ({addr, din}),
    .q     (bus_q)
  );

  assign s_cur  = strobe_t'(strb_q);
  assign addr_s = bus_q[BUS_W-1:DATA_W];
  assign data_s = bus_q[DATA_W-1:0];

  // Bank arbitration: flash enable dominates
  logic flash_sel, sram_sel, rd_ok, flash_rd, sram_rd;
  logic win_now, abort_now;

  always_comb begin
    flash_sel = !s_cur.flash_n;
    sram_sel  = !s_cur.sram_n && s_cur.flash_n;
    rd_ok     = !s_cur.oe_n && s_cur.we_n;
    flash_rd  = rd_ok && flash_sel && !flash_busy;
    sram_rd   = rd_ok && sram_sel;
    win_now   = sram_sel && !s_cur.we_n;
    abort_now = flash_sel;
  end

  // RAM write window
  logic                commit;
  logic [FLASH_AW-1:0] commit_addr;
  logic [DATA_W-1:0]   commit_data;

  wr_window #(.AW(FLASH_AW), .DW(DATA_W), .MIN_PULSE(MIN_PULSE)) u_window (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .win_now     (win_now),
    .abort_now   (abort_now),
    .addr_s      (addr_s),
    .data_s      (data_s),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data),
    .wr_err      (wr_err)
  );

  // Banks
  logic [DATA_W-1:0] sram_rd_data, flash_rd_data;
  logic              pre_ok;

  sram_bank #(.SRAM_AW(SRAM_AW), .ADDR_W(FLASH_AW), .DW(DATA_W)) u_sram (
    .clk     (clk),
    .wr      (commit),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .rd_addr (addr_s),
    .rd_data (sram_rd_data)
  );

  assign pre_ok = pre_we && standby;

  flash_bank #(.AW(FLASH_AW), .DW(DATA_W)) u_flash (
    .clk      (clk),
    .pre_wr   (pre_ok),
    .pre_addr (pre_addr),
    .pre_data (pre_data),
    .rd_addr  (addr_s),
    .rd_data  (flash_rd_data)
  );

  // Output stage
  logic [DATA_W-1:0] dout_d;
  logic              dout_en_d, standby_d;

  always_comb begin
    dout_en_d = flash_rd || sram_rd;
    standby_d = s_cur.flash_n && s_cur.sram_n;
    if (flash_rd)     dout_d = flash_rd_data;
    else if (sram_rd) dout_d = sram_rd_data;
    else              dout_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout    <= '0;
      dout_en <= 1'b0;
      standby <= 1'b1;
    end else begin
      dout    <= dout_d;
      dout_en <= dout_en_d;
      standby <= standby_d;
    end
  end

  // Cycles since reset release, so that $past never reaches before reset
  logic [2:0] age_q;
  logic       age_ok;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)        age_q <= '0;
    else if (age_q != 3'd7) age_q <= age_q + 3'd1;
  end
  assign age_ok = (age_q == 3'd7);

  assert_hiz_oe_high_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_ok && $past(out_en_n, 3)) |-> !dout_en);
  assert_standby_match_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    age_ok |-> (standby == ($past(flash_sel_n, 3) && $past(sram_sel_n, 3))));
  assert_flash_wins_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_ok && !$past(flash_sel_n, 3) && !$past(out_en_n, 3) && $past(wr_en_n, 3)
     && !$past(flash_busy, 1)) |-> dout_en);
  assert_busy_blocks_flash_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (age_ok && !$past(flash_sel_n, 3) && $past(flash_busy, 1)) |-> !dout_en);

endmodule

// File: tb/tb_combo_mem_bus.sv
module tb_combo_mem_bus;

  localparam int DW  = 8;
  localparam int FAW = 6;
  localparam int SAW = 5;
  localparam int FD  = 1 << FAW;
  localparam int SD  = 1 << SAW;

  logic           clk, rst_n;
  logic [FAW-1:0] addr, pre_addr;
  logic           flash_sel_n, sram_sel_n, out_en_n, wr_en_n;
  logic [DW-1:0]  din, pre_data, dout;
  logic           flash_busy, pre_we, dout_en, standby, wr_err;

  int checks, errors, err_seen;
  logic [DW-1:0] fm [FD];
  logic [DW-1:0] sm [SD];

  combo_mem_bus #(.DATA_W(DW), .FLASH_AW(FAW), .SRAM_AW(SAW), .MIN_PULSE(3)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .flash_sel_n(flash_sel_n),
    .sram_sel_n(sram_sel_n), .out_en_n(out_en_n), .wr_en_n(wr_en_n), .din(din),
    .flash_busy(flash_busy), .pre_we(pre_we), .pre_addr(pre_addr), .pre_data(pre_data),
    .dout(dout), .dout_en(dout_en), .standby(standby), .wr_err(wr_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) if (rst_n && wr_err) err_seen++;

  function automatic logic [DW-1:0] fpat(input int a);
    return DW'(a * 37 + 11);
  endfunction
  function automatic logic [DW-1:0] spat(input int a);
    return DW'(a * 13 + 8'h40);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic idle_bus;
    flash_sel_n = 1'b1; sram_sel_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
  endtask

  task automatic preload(input int a, input logic [DW-1:0] d);
    @(negedge clk); pre_we = 1'b1; pre_addr = FAW'(a); pre_data = d;
    @(negedge clk); pre_we = 1'b0;
  endtask

  // RAM write; sel_first picks which strobe rises first
  task automatic sram_write(input int a, input logic [DW-1:0] d, input int len, input bit sel_first);
    @(negedge clk); addr = FAW'(a); din = d; sram_sel_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b0;
    repeat (len) @(negedge clk);
    if (sel_first) sram_sel_n = 1'b1; else wr_en_n = 1'b1;
    @(negedge clk); din = ~d;
    @(negedge clk); sram_sel_n = 1'b1; wr_en_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_read(input logic fs, input logic ss, input int a,
                          output logic en, output logic [DW-1:0] q);
    @(negedge clk); addr = FAW'(a); flash_sel_n = fs; sram_sel_n = ss;
    wr_en_n = 1'b1; out_en_n = 1'b0;
    repeat (4) @(negedge clk);
    en = dout_en; q = dout;
    idle_bus();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic en;
    logic [DW-1:0] q;
    int e0;
    checks = 0; errors = 0; err_seen = 0;
    rst_n = 1'b0; idle_bus(); addr = '0; din = '0;
    flash_busy = 1'b0; pre_we = 1'b0; pre_addr = '0; pre_data = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R1: reset state
    check("R1 dout_en", 32'(dout_en), 32'd0);
    check("R1 standby", 32'(standby), 32'd1);
    check("R1 wr_err", 32'(wr_err), 32'd0);

    // Preload every flash word in standby
    for (int a = 0; a < FD; a++) begin
      fm[a] = fpat(a);
      preload(a, fm[a]);
    end

    // R6: fill the RAM, alternating which strobe rises first
    e0 = err_seen;
    for (int a = 0; a < SD; a++) begin
      sm[a] = spat(a);
      sram_write(a, sm[a], 3, a[0]);
    end
    check("R6 no error on full-length writes", 32'(err_seen), 32'(e0));
    for (int a = 0; a < SD; a++) begin
      bus_read(1'b1, 1'b0, a, en, q);
      check("R6 ram readback drive", 32'(en), 32'd1);
      check("R6 ram readback data", 32'(q), 32'(sm[a]));
    end
    for (int a = 0; a < FD; a++) begin
      bus_read(1'b0, 1'b1, a, en, q);
      check("R4 flash readback data", 32'(q), 32'(fm[a]));
    end

    // R2 R3 R4: every strobe combination at address 7
    din = sm[7];
    for (int c = 0; c < 16; c++) begin
      logic fs, ss, oe, we, exp_en;
      {fs, ss, oe, we} = 4'(c);
      @(negedge clk); addr = FAW'(7);
      flash_sel_n = fs; sram_sel_n = ss; out_en_n = oe; wr_en_n = we;
      repeat (4) @(negedge clk);
      exp_en = !oe && we && (!fs || !ss);
      check("R2 standby per combination", 32'(standby), 32'(fs && ss));
      check("R3 drive per combination", 32'(dout_en), 32'(exp_en));
      if (exp_en) check("R4 data per combination", 32'(dout), !fs ? 32'(fm[7]) : 32'(sm[7]));
      @(negedge clk); idle_bus();
      repeat (5) @(negedge clk);
    end

    // R5: address above the RAM region
    sram_write(SD + 3, 8'hA5, 3, 1'b0);
    bus_read(1'b1, 1'b0, 3, en, q);
    check("R5 alias word unchanged", 32'(q), 32'(sm[3]));
    bus_read(1'b1, 1'b0, SD + 3, en, q);
    check("R5 out-of-region drive", 32'(en), 32'd1);
    check("R5 out-of-region data zero", 32'(q), 32'd0);

    // R7: short windows
    e0 = err_seen;
    sram_write(4, 8'h99, 2, 1'b0);
    check("R7 one error pulse len 2", 32'(err_seen), 32'(e0 + 1));
    sram_write(4, 8'h98, 1, 1'b1);
    check("R7 one error pulse len 1", 32'(err_seen), 32'(e0 + 2));
    bus_read(1'b1, 1'b0, 4, en, q);
    check("R7 short writes stored nothing", 32'(q), 32'(sm[4]));

    // R8: write activity with the flash enable low
    e0 = err_seen;
    @(negedge clk); addr = FAW'(2); din = 8'h55; flash_sel_n = 1'b0; sram_sel_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b0;
    repeat (4) @(negedge clk); wr_en_n = 1'b1;
    @(negedge clk); idle_bus();
    repeat (6) @(negedge clk);
    bus_read(1'b1, 1'b0, 2, en, q);
    check("R8 ram unchanged under flash enable", 32'(q), 32'(sm[2]));
    bus_read(1'b0, 1'b1, 2, en, q);
    check("R8 flash unchanged by write enable", 32'(q), 32'(fm[2]));
    // RAM window cut short by the flash enable
    @(negedge clk); addr = FAW'(6); din = 8'h66; sram_sel_n = 1'b0;
    @(negedge clk); wr_en_n = 1'b0;
    repeat (4) @(negedge clk); flash_sel_n = 1'b0;
    repeat (2) @(negedge clk); wr_en_n = 1'b1; sram_sel_n = 1'b1;
    @(negedge clk); flash_sel_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R8 no error on interrupted window", 32'(err_seen), 32'(e0));
    bus_read(1'b1, 1'b0, 6, en, q);
    check("R8 interrupted window dropped", 32'(q), 32'(sm[6]));

    // R9: preload refused outside standby, accepted in standby
    @(negedge clk); sram_sel_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 not in standby", 32'(standby), 32'd0);
    preload(5, 8'hEE);
    @(negedge clk); idle_bus();
    repeat (5) @(negedge clk);
    bus_read(1'b0, 1'b1, 5, en, q);
    check("R9 preload outside standby ignored", 32'(q), 32'(fm[5]));
    fm[5] = 8'h5A;
    preload(5, fm[5]);
    bus_read(1'b0, 1'b1, 5, en, q);
    check("R9 preload in standby stored", 32'(q), 32'(fm[5]));

    // R10: flash busy
    flash_busy = 1'b1;
    bus_read(1'b0, 1'b1, 10, en, q);
    check("R10 flash read undriven while busy", 32'(en), 32'd0);
    sm[9] = 8'h3C;
    sram_write(9, sm[9], 3, 1'b1);
    bus_read(1'b1, 1'b0, 9, en, q);
    check("R10 ram drive while busy", 32'(en), 32'd1);
    check("R10 ram data while busy", 32'(q), 32'(sm[9]));
    flash_busy = 1'b0;
    bus_read(1'b0, 1'b1, 10, en, q);
    check("R10 flash read after busy", 32'(q), 32'(fm[10]));

    finish_run();
  end

endmodule